// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits beside one processor port and keeps account of every cache request that is still waiting for its answer. Requests fall into two classes, read-class and write-class. Each class has its own small fully associative table, and each entry is tagged by the line address: the request address with its offset inside the cache line cleared. Every request that arrives gets a one-cycle decision:

- **Issued**: an entry is allocated and stamped with the current cycle.
- **Aliased**: an entry for the same line is already outstanding.
- **BufferFull**: there is no room.
- **Rejected**: the request is malformed.

Completion responses name a line and a class. A completion frees the matching entry and reports the miss latency, which is the current cycle minus the stamp. A completion that matches nothing sets a sticky protocol-error flag.

The block keeps four stall counters. They record, for each aliased request, which kind of new request ran into which kind of outstanding entry. An age-based watchdog raises a sticky deadlock flag when an entry stays outstanding too long.

Requests and completions are single-cycle valid pulses. The block takes one of each in every cycle and has no back-pressure.

Top module: `line_req_tracker`

## Requirements
- R1: Kind codes 0 (load) and 1 (instruction fetch) are read-class. Codes 2 to 10 are write-class: store, atomic, rmw-read, rmw-write, linked-load, conditional-store, locked-read, locked-write and flush, in that order. Codes 11 to 15 are rejected with response code 3.
- R2: A request whose line offset (the low log2(LINE_BYTES) address bits) plus size exceeds LINE_BYTES is rejected with code 3. It changes no table, count or counter. An access that ends exactly at the line end is legal.
- R3: A request whose line is present in the write table or in the read table gets response code 1 (Aliased). This holds even when the block is at capacity.
- R4: A request with no alias gets code 2 (BufferFull) in two cases: the outstanding count is at least MAX_OUT, or the table of its own class has no free entry.
- R5: Any other legal request gets code 0 (Issued). It allocates an entry in the table of its class and raises the outstanding count by one. rsp_valid and rsp_code appear in the cycle after req_valid.
- R6: Stall counters only count requests that are not rejected. An alias on the write table increments wait_wr_rd when the new kind is 0, 1 or 4, and wait_wr_wr otherwise. An alias on the read table only increments wait_rd_wr when the new kind is 2 or 5, and wait_rd_rd otherwise.
- R7: A read completion (cpl_write=0) that finds its line in the read table frees that entry, and the same applies to a write completion (cpl_write=1) and the write table. In either case, one cycle later done_valid pulses with done_latency equal to the number of clock edges from acceptance to completion.
- R8: A completion whose line is absent from the table of its class sets the sticky proto_err. It changes no count and raises no done_valid.
- R9: While anything is outstanding, all entries are checked every THRESH cycles. deadlock is set, and stays set, when an entry's age has reached THRESH. Entries that live for fewer than THRESH cycles never set it.
- R10: After reset all outputs are zero. outstanding always equals the number of valid entries in both tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New request this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_kind | input | 4 | Request kind code (R1) |
| req_size | input | SIZE_W | Access size in bytes |
| cpl_valid | input | 1 | Completion this cycle |
| cpl_write | input | 1 | 1 = write-class completion, 0 = read-class |
| cpl_addr | input | ADDR_W | Completion address (offset bits ignored) |
| rsp_valid | output | 1 | Decision valid (one cycle after request) |
| rsp_code | output | 2 | 0 Issued, 1 Aliased, 2 BufferFull, 3 Rejected |
| done_valid | output | 1 | A completion matched an entry |
| done_latency | output | TIME_W | Cycles the matched request was outstanding |
| outstanding | output | $clog2(2*ENTRIES+1) | Valid entries in both tables |
| wait_wr_rd | output | CNT_W | Read-like request aliased a write entry |
| wait_wr_wr | output | CNT_W | Other request aliased a write entry |
| wait_rd_wr | output | CNT_W | Store or rmw-write aliased a read entry |
| wait_rd_rd | output | CNT_W | Other request aliased a read entry |
| deadlock | output | 1 | Sticky: an entry aged to THRESH |
| proto_err | output | 1 | Sticky: completion without a matching entry |

## Verification
The bench targets several corner cases:

- **Alias at capacity.** A design that checked capacity first would answer BufferFull to a request on an already-outstanding line, and the stall counter would not move.
- **Full table below the global limit.** If only the global limit were honoured, a request would be allocated into a table that has no free entry.
- **Access that ends exactly at the line end.** An off-by-one in the crossing test would reject it.
- **Completion in the wrong class.** A design that searched both tables would free the write entry instead of flagging a protocol error.
- **Deadlock timing.** The watchdog is driven with one entry that retires just before the threshold and one that outlives it. A wrong comparison or period would either flag the short-lived entry or miss the stale one.

Random traffic over a handful of lines then mixes aliasing, completions and the rmw and locked kinds, and checks every decision and latency against a bench model.

// File: rtl/trk_pkg.sv
// Package: shared codes and kind classification for the request tracker.
// Assumes a 4-bit kind field; codes above the flush code are illegal.
package trk_pkg;

    typedef enum logic [3:0] {
        K_LOAD    = 4'd0,
        K_FETCH   = 4'd1,
        K_STORE   = 4'd2,
        K_ATOMIC  = 4'd3,
        K_RMW_RD  = 4'd4,
        K_RMW_WR  = 4'd5,
        K_LINKED  = 4'd6,
        K_COND    = 4'd7,
        K_LOCK_RD = 4'd8,
        K_LOCK_WR = 4'd9,
        K_FLUSH   = 4'd10
    } kind_e;

    typedef enum logic [1:0] {
        RSP_ISSUED = 2'd0,
        RSP_ALIAS  = 2'd1,
        RSP_FULL   = 2'd2,
        RSP_REJECT = 2'd3
    } rsp_e;

    // True for any defined kind code.
    function automatic logic kind_known(input logic [3:0] k);
        return k <= K_FLUSH;
    endfunction

    // True for read-class kinds (kept in the read table).
    function automatic logic kind_is_read(input logic [3:0] k);
        return (k == K_LOAD) || (k == K_FETCH);
    endfunction

    // Kinds counted as read-like when they collide with a write entry.
    function automatic logic kind_readish(input logic [3:0] k);
        return (k == K_LOAD) || (k == K_FETCH) || (k == K_RMW_RD);
    endfunction

    // Kinds counted as store-like when they collide with a read entry.
    function automatic logic kind_storeish(input logic [3:0] k);
        return (k == K_STORE) || (k == K_RMW_WR);
    endfunction

endpackage

// File: rtl/line_table.sv
// Module: line_table
// One fully associative table of outstanding requests, tagged by line
// address, each entry stamped with its issue cycle. It provides a lookup
// port for alias checks, an allocate port, a free-by-line port for
// completions, an occupancy count and an "entry too old" flag.
// Assumes the caller never allocates a line already present or into a
// full table.
module line_table #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 10,
    parameter int TIME_W  = 16,
    parameter int THRESH  = 64,
    localparam int USED_W = $clog2(ENTRIES + 1),
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_hit,
    input  logic              alloc_en,
    input  logic [LINE_W-1:0] alloc_line,
    output logic              full,
    input  logic              free_en,
    input  logic [LINE_W-1:0] free_line,
    output logic              free_hit,
    output logic [TIME_W-1:0] free_stamp,
    output logic [USED_W-1:0] used,
    output logic              any_old
);

    logic [ENTRIES-1:0] vld;
    logic [LINE_W-1:0]  tag   [ENTRIES];
    logic [TIME_W-1:0]  stamp [ENTRIES];

    logic [ENTRIES-1:0] look_vec, free_vec, old_vec;
    logic [IDX_W-1:0]   slot;

    // Per-entry comparators for lookup, free and age.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign look_vec[g] = vld[g] && (tag[g] == look_line);
        assign free_vec[g] = vld[g] && (tag[g] == free_line);
        assign old_vec[g]  = vld[g] && ((now - stamp[g]) >= TIME_W'(THRESH));
    end

    assign look_hit = |look_vec;
    assign free_hit = |free_vec;
    assign any_old  = |old_vec;
    assign full     = &vld;

    // Pick the lowest free slot and the stamp of the matched entry.
    always_comb begin
        slot       = '0;
        free_stamp = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) slot = IDX_W'(i);
            if (free_vec[i]) free_stamp = stamp[i];
        end
    end

    // Count valid entries.
    always_comb begin
        used = '0;
        for (int i = 0; i < ENTRIES; i++) used = used + USED_W'(vld[i]);
    end

    // Entry state: allocate into the chosen slot, free the matched one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag[i]   <= '0;
                stamp[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (free_en && free_vec[i]) vld[i] <= 1'b0;
                if (alloc_en && (slot == IDX_W'(i))) begin
                    vld[i]   <= 1'b1;
                    tag[i]   <= alloc_line;
                    stamp[i] <= now;
                end
            end
        end
    end

    // Duplicate-line detector used only by the assertion below.
    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < ENTRIES; i++)
            for (int j = i + 1; j < ENTRIES; j++)
                if (vld[i] && vld[j] && tag[i] == tag[j]) dup = 1'b1;
    end

    a_r10_no_dup_line: assert property (@(posedge clk) disable iff (!rst_n)
        !dup);
    a_r5_alloc_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !full);
    a_r3_alloc_not_alias: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !(|(vld & ~free_vec)) || !look_hit || (look_line != alloc_line));

endmodule

// File: rtl/age_watch.sv
// Module: age_watch
// Periodic deadlock watchdog. While busy it counts THRESH cycles, then
// samples the tables' "entry too old" flag and latches a sticky alarm.
// The period restarts whenever nothing is outstanding.
// Assumes THRESH >= 2.
module age_watch #(
    parameter int THRESH = 64,
    localparam int PER_W = $clog2(THRESH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic any_old,
    output logic alarm
);

    logic [PER_W-1:0] tmr;

    // Period timer and sticky alarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr   <= '0;
            alarm <= 1'b0;
        end else if (!busy) begin
            tmr <= '0;
        end else if (tmr == PER_W'(THRESH - 1)) begin
            tmr <= '0;
            if (any_old) alarm <= 1'b1;
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

    a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> alarm);

endmodule

// File: rtl/line_req_tracker.sv
// Module: line_req_tracker (top)
// Tracks outstanding cache requests of one port in separate read and write
// tables keyed by line. Decides Issued/Aliased/BufferFull/Rejected for each
// request, matches completions, reports latency, counts alias stalls by
// kind pairing and runs the age watchdog.
// Assumes MAX_OUT <= 2*ENTRIES and LINE_BYTES a power of two.
module line_req_tracker
    import trk_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 64,
    parameter int SIZE_W     = 7,
    parameter int ENTRIES    = 4,
    parameter int MAX_OUT    = 6,
    parameter int THRESH     = 64,
    parameter int TIME_W     = 16,
    parameter int CNT_W      = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int OUT_W     = $clog2(2 * ENTRIES + 1),
    localparam int USED_W    = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_kind,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              cpl_valid,
    input  logic              cpl_write,
    input  logic [ADDR_W-1:0] cpl_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              done_valid,
    output logic [TIME_W-1:0] done_latency,
    output logic [OUT_W-1:0]  outstanding,
    output logic [CNT_W-1:0]  wait_wr_rd,
    output logic [CNT_W-1:0]  wait_wr_wr,
    output logic [CNT_W-1:0]  wait_rd_wr,
    output logic [CNT_W-1:0]  wait_rd_rd,
    output logic              deadlock,
    output logic              proto_err
);

    logic [TIME_W-1:0] now;
    logic [LINE_W-1:0] req_line, cpl_line;
    logic [OFF_W-1:0]  req_off;
    logic              rd_hit, wr_hit, rd_full, wr_full;
    logic              rd_fhit, wr_fhit, rd_old, wr_old;
    logic [TIME_W-1:0] rd_fstamp, wr_fstamp;
    logic [USED_W-1:0] rd_used, wr_used;
    logic              legal, is_rd, cpl_match;
    rsp_e              dec;
    logic              alloc_rd, alloc_wr;

    assign req_line = req_addr[ADDR_W-1:OFF_W];
    assign req_off  = req_addr[OFF_W-1:0];
    assign cpl_line = cpl_addr[ADDR_W-1:OFF_W];
    assign is_rd    = kind_is_read(req_kind);

    // Request decision: reject, then alias (write table first), then room.
    always_comb begin
        legal = kind_known(req_kind) &&
                ((32'(req_off) + 32'(req_size)) <= 32'(LINE_BYTES));
        if (!legal)
            dec = RSP_REJECT;
        else if (wr_hit || rd_hit)
            dec = RSP_ALIAS;
        else if ((outstanding >= OUT_W'(MAX_OUT)) || (is_rd ? rd_full : wr_full))
            dec = RSP_FULL;
        else
            dec = RSP_ISSUED;
    end

    assign alloc_rd  = req_valid && (dec == RSP_ISSUED) && is_rd;
    assign alloc_wr  = req_valid && (dec == RSP_ISSUED) && !is_rd;
    assign cpl_match = cpl_valid && (cpl_write ? wr_fhit : rd_fhit);

    line_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .TIME_W(TIME_W),
                 .THRESH(THRESH)) u_rd_tbl (
        .clk(clk), .rst_n(rst_n), .now(now),
        .look_line(req_line), .look_hit(rd_hit),
        .alloc_en(alloc_rd), .alloc_line(req_line), .full(rd_full),
        .free_en(cpl_valid && !cpl_write), .free_line(cpl_line),
        .free_hit(rd_fhit), .free_stamp(rd_fstamp),
        .used(rd_used), .any_old(rd_old)
    );

    line_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .TIME_W(TIME_W),
                 .THRESH(THRESH)) u_wr_tbl (
        .clk(clk), .rst_n(rst_n), .now(now),
        .look_line(req_line), .look_hit(wr_hit),
        .alloc_en(alloc_wr), .alloc_line(req_line), .full(wr_full),
        .free_en(cpl_valid && cpl_write), .free_line(cpl_line),
        .free_hit(wr_fhit), .free_stamp(wr_fstamp),
        .used(wr_used), .any_old(wr_old)
    );

    age_watch #(.THRESH(THRESH)) u_watch (
        .clk(clk), .rst_n(rst_n), .busy(outstanding != '0),
        .any_old(rd_old || wr_old), .alarm(deadlock)
    );

    // Cycle counter, outstanding count, responses and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now          <= '0;
            outstanding  <= '0;
            rsp_valid    <= 1'b0;
            rsp_code     <= '0;
            done_valid   <= 1'b0;
            done_latency <= '0;
            proto_err    <= 1'b0;
        end else begin
            now          <= now + 1'b1;
            outstanding  <= outstanding + OUT_W'(alloc_rd || alloc_wr) - OUT_W'(cpl_match);
            rsp_valid    <= req_valid;
            rsp_code     <= dec;
            done_valid   <= cpl_match;
            done_latency <= now - (cpl_write ? wr_fstamp : rd_fstamp);
            if (cpl_valid && !cpl_match) proto_err <= 1'b1;
        end
    end

    // Alias stall counters by pairing of new and outstanding kinds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_wr_rd <= '0;
            wait_wr_wr <= '0;
            wait_rd_wr <= '0;
            wait_rd_rd <= '0;
        end else if (req_valid && legal) begin
            if (wr_hit) begin
                if (kind_readish(req_kind)) wait_wr_rd <= wait_wr_rd + 1'b1;
                else                        wait_wr_wr <= wait_wr_wr + 1'b1;
            end else if (rd_hit) begin
                if (kind_storeish(req_kind)) wait_rd_wr <= wait_rd_wr + 1'b1;
                else                         wait_rd_rd <= wait_rd_rd + 1'b1;
            end
        end
    end

    a_r10_count_match: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding == OUT_W'(rd_used) + OUT_W'(wr_used));
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= OUT_W'(MAX_OUT));
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
    a_r8_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_match && !alloc_rd && !alloc_wr) |=> $stable(outstanding));
    a_r2_reject_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !legal) |-> !(alloc_rd || alloc_wr));

endmodule

// File: tb/sim_line_req_tracker.sv
module sim_line_req_tracker;

    localparam int ADDR_W = 16, LINE_BYTES = 64, SIZE_W = 7, ENTRIES = 4;
    localparam int MAX_OUT = 6, THRESH = 64, TIME_W = 16, CNT_W = 16;
    localparam int OUT_W = $clog2(2 * ENTRIES + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, cpl_valid = 1'b0, cpl_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0, cpl_addr = '0;
    logic [3:0] req_kind = '0;
    logic [SIZE_W-1:0] req_size = '0;
    logic rsp_valid, done_valid, deadlock, proto_err;
    logic [1:0] rsp_code;
    logic [TIME_W-1:0] done_latency;
    logic [OUT_W-1:0] outstanding;
    logic [CNT_W-1:0] wait_wr_rd, wait_wr_wr, wait_rd_wr, wait_rd_rd;

    line_req_tracker u0 (.*);

    always #2 clk = ~clk;

    int checks = 0, fails = 0, ecnt = 0;
    bit finished = 1'b0;
    always @(posedge clk) ecnt <= ecnt + 1;

    // Bench model: [0] read table, [1] write table.
    bit m_vld [2][ENTRIES];
    int m_line[2][ENTRIES];
    int m_stamp[2][ENTRIES];
    int e_wrrd, e_wrwr, e_rdwr, e_rdrd;
    bit e_err;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_find(input int t, input int line);
        for (int i = 0; i < ENTRIES; i++)
            if (m_vld[t][i] && m_line[t][i] == line) return i;
        return -1;
    endfunction

    function automatic int m_used(input int t);
        int n = 0;
        for (int i = 0; i < ENTRIES; i++) n += int'(m_vld[t][i]);
        return n;
    endfunction

    function automatic int m_total();
        return m_used(0) + m_used(1);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < ENTRIES; i++) m_vld[t][i] = 1'b0;
        e_wrrd = 0; e_wrwr = 0; e_rdwr = 0; e_rdrd = 0; e_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Expected response code computed from the requirements.
    task automatic do_req(input int line, input int off, input int kind, input int size,
                          input string req);
        int exp, t, slot;
        t = (kind <= 1) ? 0 : 1;
        if (kind > 10 || off + size > LINE_BYTES) exp = 3;
        else if (m_find(1, line) >= 0) begin
            exp = 1;
            if (kind == 0 || kind == 1 || kind == 4) e_wrrd++; else e_wrwr++;
        end else if (m_find(0, line) >= 0) begin
            exp = 1;
            if (kind == 2 || kind == 5) e_rdwr++; else e_rdrd++;
        end else if (m_total() >= MAX_OUT || m_used(t) == ENTRIES) exp = 2;
        else exp = 0;
        if (exp == 0) begin
            slot = -1;
            for (int i = ENTRIES - 1; i >= 0; i--) if (!m_vld[t][i]) slot = i;
            m_vld[t][slot] = 1'b1; m_line[t][slot] = line; m_stamp[t][slot] = ecnt;
        end
        req_valid = 1'b1;
        req_addr  = ADDR_W'((line << 6) | off);
        req_kind  = 4'(kind);
        req_size  = SIZE_W'(size);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && int'(rsp_code) == exp, req, int'(rsp_code), exp);
        check(int'(outstanding) == m_total(), "R10", int'(outstanding), m_total());
    endtask

    task automatic do_cpl(input int line, input bit wr, input string req);
        int t, idx, lat;
        t = wr ? 1 : 0;
        idx = m_find(t, line);
        lat = 0;
        if (idx >= 0) begin
            lat = ecnt - m_stamp[t][idx];
            m_vld[t][idx] = 1'b0;
        end else e_err = 1'b1;
        cpl_valid = 1'b1;
        cpl_write = wr;
        cpl_addr  = ADDR_W'((line << 6) | 5);
        @(posedge clk);
        @(negedge clk);
        cpl_valid = 1'b0;
        check(done_valid == (idx >= 0), req, int'(done_valid), int'(idx >= 0));
        if (idx >= 0)
            check(int'(done_latency) == lat, "R7", int'(done_latency), lat);
        check(proto_err == e_err, "R8", int'(proto_err), int'(e_err));
        check(int'(outstanding) == m_total(), "R10", int'(outstanding), m_total());
    endtask

    task automatic check_counters();
        check(int'(wait_wr_rd) == e_wrrd, "R6 wr_rd", int'(wait_wr_rd), e_wrrd);
        check(int'(wait_wr_wr) == e_wrwr, "R6 wr_wr", int'(wait_wr_wr), e_wrwr);
        check(int'(wait_rd_wr) == e_rdwr, "R6 rd_wr", int'(wait_rd_wr), e_rdwr);
        check(int'(wait_rd_rd) == e_rdrd, "R6 rd_rd", int'(wait_rd_rd), e_rdrd);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R10: reset state
        check(outstanding == '0 && !rsp_valid && !done_valid, "R10 reset", int'(outstanding), 0);
        check(!deadlock && !proto_err, "R10 reset flags", int'(deadlock) + int'(proto_err), 0);
        check_counters();

        do_req(4, 0, 0, 8, "R5 load issued");
        do_req(4, 8, 2, 4, "R3 store on read line");      // rd_wr
        do_req(4, 16, 1, 4, "R3 fetch on read line");     // rd_rd
        do_req(5, 0, 2, 8, "R5 store issued");
        do_req(5, 0, 0, 8, "R3 load on write line");      // wr_rd
        do_req(5, 0, 3, 8, "R3 atomic on write line");    // wr_wr
        do_req(5, 0, 4, 8, "R6 rmw-read on write line");  // wr_rd
        do_req(4, 0, 8, 8, "R6 locked-read on read line");// rd_rd
        do_req(6, 60, 0, 8, "R2 crossing rejected");
        do_req(6, 56, 0, 8, "R2 exact fit issued");
        do_req(7, 0, 11, 4, "R1 unknown kind rejected");
        do_req(7, 0, 15, 4, "R1 unknown kind rejected");
        do_req(8, 0, 10, 4, "R1 flush is write-class");
        do_req(9, 0, 6, 4, "R1 linked-load is write-class");
        do_req(10, 0, 9, 4, "R5 fill write table");
        do_req(11, 0, 0, 4, "R4 global limit full");
        do_req(4, 0, 0, 4, "R3 alias beats capacity");
        check_counters();
        idle(3);
        do_cpl(4, 1'b0, "R7 read completion");
        do_req(11, 0, 2, 4, "R4 own table full");
        do_req(11, 0, 1, 4, "R5 read fits");
        do_cpl(5, 1'b0, "R8 wrong-class completion");
        do_cpl(12, 1'b1, "R8 unknown line completion");
        do_cpl(5, 1'b1, "R7 write completion");
        do_cpl(6, 1'b0, "R7 read completion");
        do_cpl(8, 1'b1, "R7 write completion");
        do_cpl(9, 1'b1, "R7 write completion");
        do_cpl(10, 1'b1, "R7 write completion");
        do_cpl(11, 1'b0, "R7 read completion");
        check_counters();
        check(!deadlock, "R9 no stale entry", int'(deadlock), 0);

        // R9 deadlock watchdog
        do_reset();
        do_req(20, 0, 0, 4, "R9 setup");
        idle(THRESH - 8);
        do_cpl(20, 1'b0, "R9 short-lived completes");
        check(!deadlock, "R9 short-lived", int'(deadlock), 0);
        do_req(21, 0, 2, 4, "R9 setup");
        idle(THRESH + 6);
        check(deadlock, "R9 stale entry flagged", int'(deadlock), 1);
        idle(THRESH);
        check(deadlock, "R9 flag sticky", int'(deadlock), 1);

        // Random phase against the bench model
        do_reset();
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom_range(99));
            if (r < 60) begin
                do_req(int'($urandom_range(7)) + 1, int'($urandom_range(63)),
                       int'($urandom_range(11)), int'($urandom_range(16, 1)), "R5 random request");
            end else if (r < 95 && m_total() > 0) begin
                int t, i;
                do begin
                    t = int'($urandom_range(1));
                    i = int'($urandom_range(ENTRIES - 1));
                end while (!m_vld[t][i]);
                do_cpl(m_line[t][i], t == 1, "R7 random completion");
            end else begin
                do_cpl(int'($urandom_range(7)) + 1, $urandom_range(1) == 1, "R8 random completion");
            end
        end
        check_counters();

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule